// File: doc/BRIEF.md
# Parity-Checked SPI Register Access Slave

This block is the serial front end of a small sensor-style register bank. A host talks to it over a four-wire SPI link in mode 0: SCK idles low, MOSI is sampled on rising SCK edges, and MISO changes on falling SCK edges. Every transaction is one 16-bit frame, bracketed by a falling and then a rising chip select. The SCK, CSB and MOSI lines are asynchronous. They are resynchronised into a fast system clock, and all frame logic runs on edge events derived there.

The first byte the host sends holds a register address, a direction flag and an odd parity bit. The second byte holds write data. The reply starts with a status byte: a frame-error flag for the previous frame, three live status flags, a fixed bit pattern, and a parity bit for the data byte. The addressed register's contents follow as the data byte. The block reaches the register bank through a parallel port: a combinational read address and data pair, and a one-cycle write strobe. A write is issued only after chip select rises, and only when the frame was well formed.

Top module: `spi_regaccess_slave`

## Requirements
- R1: After reset, miso_oe and reg_we are 0, and the frame-error flag sent in the first frame is 0.
- R2: miso_oe is 1 only while CSB is low. It rises a few system clocks after CSB falls, so the first reply bit is valid before the first SCK rising edge.
- R3: The 16 reply bits go out MSB first: bit15 is 0, bit14 is the previous frame's error flag, bits 13..11 are stat_por, stat_selftest and stat_sat as sampled at CSB fall, bit10 is 0, bit9 is 1, bit8 is data parity, and bits 7..0 are data.
- R4: The data parity bit makes the count of ones over bit8..bit0 odd.
- R5: The data byte is the register value at the addressed location. On a write frame it is the value held before that write.
- R6: A valid write frame produces exactly one reg_we pulse after CSB rises, carrying the frame's address and data byte.
- R7: A read frame (direction flag 0) never pulses reg_we. Its second byte has no effect.
- R8: A frame whose command byte does not have odd parity writes nothing, and the next frame reports an error flag of 1.
- R9: A frame with other than exactly 16 SCK rising edges writes nothing, and the next frame reports an error flag of 1.
- R10: A valid frame clears the error flag, so the frame after it reports 0.
- R11: The command byte is received MSB first as address[5:0], then the direction flag (1 = write), then the parity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock, idles low |
| csb | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host, 0 when not enabled |
| miso_oe | output | 1 | Output enable for the MISO pad driver |
| reg_addr | output | 6 | Read address presented to the register bank |
| reg_rdata | input | 8 | Combinational read data for reg_addr |
| reg_we | output | 1 | One-cycle write strobe |
| reg_waddr | output | 6 | Write address |
| reg_wdata | output | 8 | Write data |
| stat_por | input | 1 | Power-on reset status flag |
| stat_selftest | input | 1 | Self-test error flag |
| stat_sat | input | 1 | Output saturation flag |

## Verification
The bench writes and then reads back all 64 addresses, with changing status inputs and a data byte that should be ignored on reads. A design that commits too early would return the new value in the write frame. A design with a misplaced status field or a wrong parity polarity would mismatch on a subset of the addresses. It then sends bad-parity, 12-edge and 17-edge write frames. A design that wrote before validating would corrupt the register, and one that failed to latch or clear the error flag would show the wrong bit14 in the following two frames.

// File: rtl/spi_ra_pkg.sv
package spi_ra_pkg;
  localparam int unsigned ADDR_W  = 6;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned CMD_W   = ADDR_W + 2;
  localparam int unsigned FRAME_W = CMD_W + DATA_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W) + 1;

  typedef struct packed {
    logic por;
    logic selftest;
    logic sat;
  } stat_t;

  // parity bit that makes data plus bit an odd count of ones
  function automatic logic odd_fill(input logic [DATA_W-1:0] d);
    return ~(^d);
  endfunction

  // command byte (address, direction, parity) must hold an odd count of ones
  function automatic logic cmd_par_ok(input logic [CMD_W-1:0] c);
    return ^c;
  endfunction

  function automatic logic [FRAME_W-1:0] tx_word(input logic ferr, input stat_t st,
                                                 input logic dpar, input logic [DATA_W-1:0] d);
    return {1'b0, ferr, st, 1'b0, 1'b1, dpar, d};
  endfunction
endpackage

// File: rtl/spi_ra_sync.sv
module spi_ra_sync #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  localparam int unsigned DEPTH = STAGES + 1;
  logic [WIDTH-1:0] chain [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) chain[k] <= RST_VAL;
    end else begin
      chain[0] <= din;
      for (int k = 1; k < DEPTH; k++) chain[k] <= chain[k-1];
    end
  end

  assign sync_o = chain[STAGES-1];
  assign rise_o = chain[STAGES-1] & ~chain[STAGES];
  assign fall_o = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/spi_ra_rx.sv
module spi_ra_rx
  import spi_ra_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic              sck_rise,
  input  logic              mosi,
  output logic [ADDR_W-1:0] addr_q,
  output logic              addr_ready,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              cmd_ok,
  output logic              frame_valid,
  output logic              frame_err,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(ADDR_W - 1);
  localparam int unsigned RW_POS = DATA_W + 1;

  logic [FRAME_W-1:0] sh;

  assign cmd_ok      = cmd_par_ok(sh[FRAME_W-1 -: CMD_W]);
  assign frame_valid = (bit_cnt == CNT_FULL) && cmd_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh         <= '0;
      bit_cnt    <= '0;
      addr_q     <= '0;
      addr_ready <= 1'b0;
      frame_err  <= 1'b0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
    end else begin
      wr_en      <= 1'b0;
      addr_ready <= 1'b0;
      if (frame_start) begin
        sh      <= '0;
        bit_cnt <= '0;
      end else if (sck_rise && active) begin
        sh <= {sh[FRAME_W-2:0], mosi};
        if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CNT_ADDR) begin
          addr_q     <= {sh[ADDR_W-2:0], mosi};
          addr_ready <= 1'b1;
        end
      end
      if (frame_end) begin
        frame_err <= !frame_valid;
        wr_en     <= frame_valid && sh[RW_POS];
        wr_addr   <= sh[FRAME_W-1 -: ADDR_W];
        wr_data   <= sh[DATA_W-1:0];
      end
    end
  end
endmodule

// File: rtl/spi_ra_tx.sv
module spi_ra_tx
  import spi_ra_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic              sck_fall,
  input  logic              addr_ready,
  input  logic [DATA_W-1:0] rd_data,
  input  stat_t             status,
  input  logic              ferr,
  output logic              miso,
  output logic              miso_oe,
  output logic [CNT_W-1:0]  tx_idx
);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  stat_t              stat_q;
  logic               ferr_q;
  logic               dpar_q;
  logic [DATA_W-1:0]  data_q;
  logic [FRAME_W-1:0] word;
  logic [FRAME_W-1:0] shifted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miso_oe <= 1'b0;
      tx_idx  <= '0;
      stat_q  <= '0;
      ferr_q  <= 1'b0;
      data_q  <= '0;
      dpar_q  <= 1'b1;
    end else begin
      if (frame_start) begin
        miso_oe <= 1'b1;
        tx_idx  <= '0;
        stat_q  <= status;
        ferr_q  <= ferr;
        data_q  <= '0;
        dpar_q  <= odd_fill('0);
      end else if (frame_end) begin
        miso_oe <= 1'b0;
      end else if (sck_fall && miso_oe && tx_idx != CNT_MAX) begin
        tx_idx <= tx_idx + 1'b1;
      end
      if (addr_ready) begin
        data_q <= rd_data;
        dpar_q <= odd_fill(rd_data);
      end
    end
  end

  assign word    = tx_word(ferr_q, stat_q, dpar_q, data_q);
  assign shifted = word << tx_idx;
  assign miso    = miso_oe && (tx_idx < CNT_FULL) && shifted[FRAME_W-1];
endmodule

// File: rtl/spi_regaccess_slave.sv
module spi_regaccess_slave
  import spi_ra_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              csb,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  output logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_waddr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic              stat_por,
  input  logic              stat_selftest,
  input  logic              stat_sat
);
  localparam int unsigned N_LINES = 3;
  localparam int unsigned I_CSB = 2;
  localparam int unsigned I_SCK = 1;
  localparam int unsigned I_MOSI = 0;

  logic [N_LINES-1:0] line_s, line_rise, line_fall;
  logic csb_s, csb_fall, csb_rise, sck_rise, sck_fall, mosi_s;
  logic addr_ready, cmd_ok, frame_valid, frame_err;
  logic [CNT_W-1:0] bit_cnt, tx_idx;
  logic unused_lines;
  stat_t status;

  spi_ra_sync #(
    .WIDTH(N_LINES), .STAGES(SYNC_STAGES), .RST_VAL(N_LINES'(1) << I_CSB)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .din({csb, sck, mosi}),
    .sync_o(line_s), .rise_o(line_rise), .fall_o(line_fall)
  );

  assign csb_s    = line_s[I_CSB];
  assign csb_fall = line_fall[I_CSB];
  assign csb_rise = line_rise[I_CSB];
  assign sck_rise = line_rise[I_SCK];
  assign sck_fall = line_fall[I_SCK];
  assign mosi_s   = line_s[I_MOSI];
  assign unused_lines = ^{line_s[I_SCK], line_rise[I_MOSI], line_fall[I_MOSI]};
  assign status   = '{por: stat_por, selftest: stat_selftest, sat: stat_sat};

  spi_ra_rx u_rx (
    .clk(clk), .rst_n(rst_n), .active(!csb_s),
    .frame_start(csb_fall), .frame_end(csb_rise),
    .sck_rise(sck_rise), .mosi(mosi_s),
    .addr_q(reg_addr), .addr_ready(addr_ready), .bit_cnt(bit_cnt),
    .cmd_ok(cmd_ok), .frame_valid(frame_valid), .frame_err(frame_err),
    .wr_en(reg_we), .wr_addr(reg_waddr), .wr_data(reg_wdata)
  );

  spi_ra_tx u_tx (
    .clk(clk), .rst_n(rst_n),
    .frame_start(csb_fall), .frame_end(csb_rise), .sck_fall(sck_fall),
    .addr_ready(addr_ready), .rd_data(reg_rdata), .status(status),
    .ferr(frame_err), .miso(miso), .miso_oe(miso_oe), .tx_idx(tx_idx)
  );
endmodule

// File: rtl/spi_ra_checks.sv
module spi_ra_checks
  import spi_ra_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             csb_s,
  input logic             csb_fall,
  input logic             frame_end,
  input logic [CNT_W-1:0] bit_cnt,
  input logic [CNT_W-1:0] tx_idx,
  input logic             cmd_ok,
  input logic             reg_we,
  input logic             miso,
  input logic             miso_oe
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

  assert_oe_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (csb_s && $past(csb_s)) |-> !miso_oe);

  assert_oe_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miso_oe) |-> $past(csb_fall));

  assert_fixed_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_oe && tx_idx == CNT_W'(6)) |-> miso);

  assert_fixed_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_oe && (tx_idx == CNT_W'(0) || tx_idx == CNT_W'(5))) |-> !miso);

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  assert_full_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> ($past(frame_end) && $past(bit_cnt) == FULL));

  assert_parity_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(cmd_ok));
endmodule

bind spi_regaccess_slave spi_ra_checks u_checks (
  .clk(clk), .rst_n(rst_n), .csb_s(csb_s), .csb_fall(csb_fall),
  .frame_end(csb_rise), .bit_cnt(bit_cnt), .tx_idx(tx_idx), .cmd_ok(cmd_ok),
  .reg_we(reg_we), .miso(miso), .miso_oe(miso_oe)
);

// File: tb/tb_spi_regaccess_slave.sv
module tb_spi_regaccess_slave;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, sck, csb, mosi, miso, miso_oe, reg_we;
  logic stat_por, stat_selftest, stat_sat;
  logic [5:0] reg_addr, reg_waddr;
  logic [7:0] reg_rdata, reg_wdata;

  logic [7:0] bank [64];
  logic [7:0] expv [64];
  int we_cnt = 0;
  int tests = 0;
  int fails = 0;

  assign reg_rdata = bank[reg_addr];
  always @(posedge clk) if (reg_we) begin
    bank[reg_waddr] <= reg_wdata;
    we_cnt <= we_cnt + 1;
  end

  spi_regaccess_slave dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .csb(csb), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .stat_por(stat_por), .stat_selftest(stat_selftest), .stat_sat(stat_sat)
  );

  task automatic chk(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp_v);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  function automatic logic [7:0] cmd(input logic [5:0] a, input logic rw, input logic good);
    logic p;
    p = ~(^{a, rw});
    return {a, rw, good ? p : ~p};
  endfunction

  function automatic logic [15:0] reply(input logic ferr, input logic [2:0] st, input logic [7:0] d);
    logic dp;
    dp = ((d[0]+d[1]+d[2]+d[3]+d[4]+d[5]+d[6]+d[7]) % 2 == 0);
    return {1'b0, ferr, st, 1'b0, 1'b1, dp, d};
  endfunction

  task automatic frame(input logic [15:0] w, input int nbits, output logic [15:0] rx, output logic oe_seen);
    rx = '0;
    oe_seen = 1'b1;
    @(negedge clk) csb = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? w[15-i] : 1'b0;
      repeat (6) @(negedge clk);
      if (i < 16) begin
        rx[15-i] = miso;
        oe_seen = oe_seen & miso_oe;
      end
      sck = 1'b1;
      repeat (6) @(negedge clk);
      sck = 1'b0;
    end
    repeat (6) @(negedge clk);
    csb = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic set_stat(input logic [2:0] s);
    {stat_por, stat_selftest, stat_sat} = s;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] rx;
    logic oe;
    int w0;
    rst_n = 1'b0; sck = 1'b0; csb = 1'b1; mosi = 1'b0;
    set_stat(3'b000);
    for (int a = 0; a < 64; a++) begin
      bank[a] = 8'(a) ^ 8'h5A;
      expv[a] = 8'(a) ^ 8'h5A;
    end
    repeat (5) @(negedge clk);
    chk(miso_oe == 1'b0 && reg_we == 1'b0, "R1 reset outputs", {14'b0, miso_oe, reg_we}, 16'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R11 R5 R6: write sweep over every address, reply carries old value
    for (int a = 0; a < 64; a++) begin
      logic [7:0] d;
      d = 8'((a * 37 + 5) & 255);
      set_stat(3'(a));
      w0 = we_cnt;
      frame({cmd(6'(a), 1'b1, 1'b1), d}, 16, rx, oe);
      chk(rx == reply(1'b0, 3'(a), expv[a]), (a == 0) ? "R1 R3 R4 R5 write reply" : "R3 R4 R5 write reply", rx, reply(1'b0, 3'(a), expv[a]));
      chk(we_cnt == w0 + 1, "R6 one write strobe", 16'(we_cnt - w0), 16'd1);
      if (a == 0) begin
        chk(oe == 1'b1, "R2 enable during frame", {15'b0, oe}, 16'd1);
        chk(miso_oe == 1'b0, "R2 enable off after frame", {15'b0, miso_oe}, 16'd0);
      end
      expv[a] = d;
    end

    // R7 R11: read sweep with a junk second byte
    for (int a = 0; a < 64; a++) begin
      set_stat(3'(63 - a));
      w0 = we_cnt;
      frame({cmd(6'(a), 1'b0, 1'b1), ~expv[a]}, 16, rx, oe);
      chk(rx == reply(1'b0, 3'(63 - a), expv[a]), "R11 R3 R4 R5 read reply", rx, reply(1'b0, 3'(63 - a), expv[a]));
      chk(we_cnt == w0, "R7 read writes nothing", 16'(we_cnt - w0), 16'd0);
    end

    // R8: bad command parity
    set_stat(3'b101);
    w0 = we_cnt;
    frame({cmd(6'd5, 1'b1, 1'b0), 8'hC3}, 16, rx, oe);
    chk(we_cnt == w0, "R8 bad parity no strobe", 16'(we_cnt - w0), 16'd0);
    frame({cmd(6'd5, 1'b0, 1'b1), 8'h00}, 16, rx, oe);
    chk(rx == reply(1'b1, 3'b101, expv[5]), "R8 error flag and data kept", rx, reply(1'b1, 3'b101, expv[5]));
    frame({cmd(6'd5, 1'b0, 1'b1), 8'h00}, 16, rx, oe);
    chk(rx == reply(1'b0, 3'b101, expv[5]), "R10 flag cleared", rx, reply(1'b0, 3'b101, expv[5]));

    // R9: short frame
    set_stat(3'b010);
    w0 = we_cnt;
    frame({cmd(6'd9, 1'b1, 1'b1), 8'h11}, 12, rx, oe);
    chk(we_cnt == w0, "R9 short frame no strobe", 16'(we_cnt - w0), 16'd0);
    frame({cmd(6'd9, 1'b0, 1'b1), 8'h00}, 16, rx, oe);
    chk(rx == reply(1'b1, 3'b010, expv[9]), "R9 short frame flagged", rx, reply(1'b1, 3'b010, expv[9]));

    // R9: long frame, then a second bad frame back to back
    w0 = we_cnt;
    frame({cmd(6'd10, 1'b1, 1'b1), 8'h22}, 17, rx, oe);
    chk(we_cnt == w0, "R9 long frame no strobe", 16'(we_cnt - w0), 16'd0);
    frame({cmd(6'd10, 1'b1, 1'b0), 8'h33}, 16, rx, oe);
    chk(rx == reply(1'b1, 3'b010, expv[10]), "R9 long frame flagged", rx, reply(1'b1, 3'b010, expv[10]));
    frame({cmd(6'd10, 1'b0, 1'b1), 8'h00}, 16, rx, oe);
    chk(rx == reply(1'b1, 3'b010, expv[10]), "R8 repeated error flagged", rx, reply(1'b1, 3'b010, expv[10]));
    frame({cmd(6'd63, 1'b0, 1'b1), 8'h00}, 16, rx, oe);
    chk(rx == reply(1'b0, 3'b010, expv[63]), "R10 valid frame clears flag", rx, reply(1'b0, 3'b010, expv[63]));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule